// File: doc/BRIEF.md
# Page-Buffered Serial Write Controller

This block sits behind a serial command decoder in a 16K x 8 nonvolatile storage subsystem. A write command presents a start address, then a stream of data bytes. The controller keeps the bytes in a 64-entry page buffer. Each buffer entry has a loaded flag. After the command it commits the loaded entries to the storage array as one timed write cycle. Byte addresses step upward inside the current 64-byte page and wrap back to the page's first byte. They never move into the next page.

A commit starts only on a chip-select rise that lands exactly on a byte boundary. At least one byte must have been received, and the protection logic must grant permission. In every other case the buffered bytes are thrown away. The write cycle is self-timed and lasts a parameterised number of system clocks. During the cycle the busy flag is high, and the rest of the chip uses it to refuse array reads. A one-cycle done pulse in the last busy cycle tells the status logic to clear its write-enable latch.

The controller is a four-state machine:
- ST_IDLE waits for a command start.
- ST_LOAD fills the buffer.
- ST_COMMIT scans all 64 buffer entries, one per clock, and issues an array write for each loaded entry.
- ST_WAIT holds busy until the cycle timer expires.

It has these transitions:
- IDLE to LOAD on `cmd_start`.
- LOAD to LOAD on a repeated `cmd_start`, which restarts loading.
- LOAD to COMMIT on an accepted chip-select rise.
- LOAD to IDLE on a rejected chip-select rise.
- COMMIT to WAIT after the scan index reaches 63.
- WAIT to IDLE when the timer expires.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `arr_we` are all 0.
- R2: The array address of every write is 14 bits. Bits 15:14 of `start_addr` are ignored. The page number is `start_addr[13:6]`, and the first byte goes to offset `start_addr[5:0]`.
- R3: Each data byte goes to the offset after the previous byte's offset. Offset 63 is followed by offset 0 of the same page. A later byte for an offset replaces an earlier one, so only the last value written to each offset reaches the array.
- R4: A commit writes only the offsets that were loaded during this command. Every other array location keeps its value.
- R5: A chip-select rise with `bit_aligned` = 0 cancels the command. No array write occurs, and `busy` stays 0.
- R6: A chip-select rise after zero data bytes starts no write cycle. `busy` stays 0.
- R7: A chip-select rise with `wr_allowed` = 0 discards the buffer. `busy` is never raised.
- R8: After an accepted chip-select rise, `busy` is 1 from the next cycle for exactly `WC_CYCLES` consecutive cycles. Every array write falls inside that window.
- R9: `done` pulses for one cycle, in the final busy cycle. `busy` is 0 in the cycle after `done`.
- R10: While `busy` is 1, `cmd_start`, `byte_valid` and `cs_rise` have no effect. They cause no later write and no new busy period.
- R11: Every command starts with an empty buffer. Bytes from a cancelled or earlier command are never written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: a write command begins; start_addr is valid |
| start_addr | input | 16 | Command start address; bits 15:14 are ignored |
| byte_valid | input | 1 | Pulse: one complete data byte is on byte_data |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Pulse: chip select has gone inactive |
| bit_aligned | input | 1 | 1 when the chip-select rise falls on a byte boundary |
| wr_allowed | input | 1 | Write permission from the protection logic |
| busy | output | 1 | Write cycle in progress; array reads must be refused |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 14 | Array write address |
| arr_wdata | output | 8 | Array write data |
| done | output | 1 | One-cycle pulse at the end of the write cycle |

## Verification
The assertions assume the following about the inputs:
- `cmd_start`, `byte_valid` and `cs_rise` are single-cycle pulses.
- No two of these pulses share a cycle outside a busy period.
- `bit_aligned` and `wr_allowed` are valid in the cycle of `cs_rise`.

The page-match check relies on this, because it records the page from an accepted `cmd_start`. The stimulus drives each pulse for exactly one cycle and in sequence. It deliberately mixes pulses only inside a busy window, where R10 says they are ignored. Random byte counts up to 69 make the in-page wrap and overwrite occur naturally.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_WAIT   = 2'd3
    } pwc_state_e;

endpackage

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
    parameter int PAGE_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [OFS_W-1:0]  start_ofs,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_loaded,
    output logic              any_loaded
);

    logic [OFS_W-1:0]  ptr_q;
    logic [PAGE_BYTES-1:0] mask_q;
    logic [DATA_W-1:0] ent_q [PAGE_BYTES];

    // Write pointer: power-of-two page, so plain increment wraps in-page.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (restart) begin
            ptr_q <= start_ofs;
        end else if (wr_en) begin
            ptr_q <= ptr_q + OFS_W'(1);
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_ent
        logic hit;
        assign hit = wr_en && (ptr_q == OFS_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[g] <= 1'b0;
            end else if (restart) begin
                mask_q[g] <= 1'b0;
            end else if (hit) begin
                mask_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else if (hit) begin
                ent_q[g] <= wr_data;
            end
        end
    end

    assign rd_data    = ent_q[rd_idx];
    assign rd_loaded  = mask_q[rd_idx];
    assign any_loaded = |mask_q;

endmodule

// File: rtl/pwc_cycle_timer.sv
module pwc_cycle_timer #(
    parameter int WC_CYCLES = 1250000,
    localparam int CNT_W    = $clog2(WC_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(WC_CYCLES - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
    import pwc_pkg::*;
#(
    parameter int CMD_ADDR_W = 16,
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64,
    parameter int WC_CYCLES  = 1250000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_start,
    input  logic [CMD_ADDR_W-1:0] start_addr,
    input  logic                  byte_valid,
    input  logic [DATA_W-1:0]     byte_data,
    input  logic                  cs_rise,
    input  logic                  bit_aligned,
    input  logic                  wr_allowed,
    output logic                  busy,
    output logic                  arr_we,
    output logic [ADDR_W-1:0]     arr_addr,
    output logic [DATA_W-1:0]     arr_wdata,
    output logic                  done
);

    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFS_W;
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PAGE_BYTES - 1);

    pwc_state_e state_q, state_d;

    logic [ADDR_W-1:0] start_trim;
    logic [PG_W-1:0]   page_q;
    logic [OFS_W-1:0]  scan_q;
    logic              start_ok;
    logic              commit_go;
    logic              load_wr;
    logic              buf_loaded;
    logic              buf_any;
    logic [DATA_W-1:0] buf_data;
    logic              tmr_expired;

    // Upper command-address bits are dropped here by truncation.
    assign start_trim = ADDR_W'(start_addr);

    assign start_ok  = cmd_start &&
                       ((state_q == ST_IDLE) || ((state_q == ST_LOAD) && !cs_rise));
    assign commit_go = (state_q == ST_LOAD) && cs_rise && bit_aligned &&
                       buf_any && wr_allowed;
    assign load_wr   = (state_q == ST_LOAD) && byte_valid && !cs_rise && !cmd_start;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (cs_rise) begin
                    state_d = commit_go ? ST_COMMIT : ST_IDLE;
                end
            end
            ST_COMMIT: begin
                if (scan_q == LAST_OFS) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Page number latch and commit scan index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            scan_q <= '0;
        end else begin
            if (start_ok) begin
                page_q <= start_trim[ADDR_W-1:OFS_W];
            end
            if (commit_go) begin
                scan_q <= '0;
            end else if (state_q == ST_COMMIT) begin
                scan_q <= scan_q + OFS_W'(1);
            end
        end
    end

    pwc_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (start_ok),
        .start_ofs  (start_trim[OFS_W-1:0]),
        .wr_en      (load_wr),
        .wr_data    (byte_data),
        .rd_idx     (scan_q),
        .rd_data    (buf_data),
        .rd_loaded  (buf_loaded),
        .any_loaded (buf_any)
    );

    pwc_cycle_timer #(
        .WC_CYCLES (WC_CYCLES)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (commit_go),
        .run     (busy),
        .expired (tmr_expired)
    );

    // Outputs
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        arr_we    = 1'b0;
        arr_addr  = {page_q, scan_q};
        arr_wdata = buf_data;
        unique case (state_q)
            ST_IDLE, ST_LOAD: begin
                busy = 1'b0;
            end
            ST_COMMIT: begin
                busy   = 1'b1;
                arr_we = buf_loaded;
            end
            ST_WAIT: begin
                busy = 1'b1;
                done = tmr_expired;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
    parameter int CMD_ADDR_W = 16,
    parameter int ADDR_W     = 14,
    parameter int PAGE_BYTES = 64,
    parameter int WC_CYCLES  = 1250000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_start,
    input logic [CMD_ADDR_W-1:0] start_addr,
    input logic                  cs_rise,
    input logic                  bit_aligned,
    input logic                  wr_allowed,
    input logic                  busy,
    input logic                  arr_we,
    input logic [ADDR_W-1:0]     arr_addr,
    input logic                  done
);

    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFS_W;
    localparam int CNT_W = $clog2(WC_CYCLES + 2);

    initial begin
        a_params_r8 : assert (WC_CYCLES > PAGE_BYTES && (1 << OFS_W) == PAGE_BYTES);
    end

    logic [CNT_W-1:0] bcnt_q;
    logic [PG_W-1:0]  page_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q      <= '0;
            page_seen_q <= '0;
        end else begin
            bcnt_q <= busy ? bcnt_q + CNT_W'(1) : '0;
            if (cmd_start && !busy && !cs_rise) begin
                page_seen_q <= start_addr[ADDR_W-1:OFS_W];
            end
        end
    end

    p_page_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_addr[ADDR_W-1:OFS_W] == page_seen_q));

    p_we_busy_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    p_busy_start_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise && bit_aligned && wr_allowed));

    p_busy_len_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt_q < CNT_W'(WC_CYCLES)));

    p_busy_end_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(bcnt_q) == CNT_W'(WC_CYCLES - 1)));

    p_done_in_busy_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_done_ends_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_fall_done_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

endmodule

bind page_write_ctrl pwc_checker #(
    .CMD_ADDR_W (CMD_ADDR_W),
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .WC_CYCLES  (WC_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .start_addr  (start_addr),
    .cs_rise     (cs_rise),
    .bit_aligned (bit_aligned),
    .wr_allowed  (wr_allowed),
    .busy        (busy),
    .arr_we      (arr_we),
    .arr_addr    (arr_addr),
    .done        (done)
);

// File: tb/sim_page_write_ctrl.sv
`timescale 1ns/1ps
module sim_page_write_ctrl;

    localparam int WC    = 100;
    localparam int DEPTH = 16384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [15:0] start_addr = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        cs_rise = 1'b0;
    logic        bit_aligned = 1'b0;
    logic        wr_allowed = 1'b0;
    logic        busy, arr_we, done;
    logic [13:0] arr_addr;
    logic [7:0]  arr_wdata;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 0;

    logic [7:0] ram [DEPTH];
    logic [7:0] exp_mem [DEPTH];

    always #2 clk = ~clk;

    page_write_ctrl #(.WC_CYCLES(WC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
        .bit_aligned(bit_aligned), .wr_allowed(wr_allowed), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .done(done)
    );

    always @(posedge clk) begin
        if (arr_we) ram[arr_addr] <= arr_wdata;
    end

    function automatic int loc(input logic [15:0] a, input int ofs);
        return {a[13:6], 6'(ofs)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic chk_mem(input string req);
        int bad = -1;
        for (int i = 0; i < DEPTH; i++) begin
            if (bad < 0 && ram[i] !== exp_mem[i]) bad = i;
        end
        if (bad < 0) chk(1'b1, req, "array", 0, 0);
        else chk(1'b0, req, $sformatf("array[%0d]", bad), int'(ram[bad]), int'(exp_mem[bad]));
    endtask

    // One write command. intrude: drive a foreign command while busy (R10).
    task automatic run_cmd(input logic [15:0] addr, input int nbytes, input bit aligned,
                           input bit allow, input bit intrude, input string req);
        logic [7:0] pb [64];
        bit         pm [64];
        int         ptr;
        int         cnt;
        int         dn;
        int         dn_at;
        bit         commit;
        for (int j = 0; j < 64; j++) begin pm[j] = 0; pb[j] = '0; end
        @(negedge clk);
        cmd_start = 1'b1; start_addr = addr;
        @(negedge clk);
        cmd_start = 1'b0;
        ptr = int'(addr[5:0]);
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            byte_valid = 1'b1; byte_data = d;
            pb[ptr] = d; pm[ptr] = 1; ptr = (ptr + 1) % 64;
            @(negedge clk);
            byte_valid = 1'b0;
            if ($urandom % 4 == 0) @(negedge clk);
        end
        cs_rise = 1'b1; bit_aligned = aligned; wr_allowed = allow;
        @(negedge clk);
        cs_rise = 1'b0; bit_aligned = 1'b0; wr_allowed = 1'b0;
        commit = aligned && allow && (nbytes > 0);
        cnt = 0; dn = 0; dn_at = -1;
        if (commit) begin
            while (busy && cnt < WC + 10) begin
                if (done) begin dn++; dn_at = cnt; end
                if (intrude) begin
                    if (cnt == 3) begin cmd_start = 1'b1; start_addr = addr ^ 16'h0100; end
                    if (cnt == 4) begin cmd_start = 1'b0; byte_valid = 1'b1; byte_data = 8'hA5; end
                    if (cnt == 6) begin byte_valid = 1'b0; cs_rise = 1'b1; bit_aligned = 1'b1; wr_allowed = 1'b1; end
                    if (cnt == 7) begin cs_rise = 1'b0; bit_aligned = 1'b0; wr_allowed = 1'b0; end
                end
                cnt++;
                @(negedge clk);
            end
            chk(cnt == WC, "R8", "busy length", cnt, WC);
            chk(dn == 1, "R9", "done pulses", dn, 1);
            chk(dn_at == WC - 1, "R9", "done position", dn_at, WC - 1);
            for (int j = 0; j < 64; j++) if (pm[j]) exp_mem[loc(addr, j)] = pb[j];
        end else begin
            for (int k = 0; k < 6; k++) begin
                if (busy) cnt++;
                @(negedge clk);
            end
            chk(cnt == 0, req, "busy while not committing", cnt, 0);
        end
        if (intrude) begin
            cnt = 0;
            for (int k = 0; k < 6; k++) begin
                if (busy) cnt++;
                @(negedge clk);
            end
            chk(cnt == 0, "R10", "busy after ignored command", cnt, 0);
        end
        chk_mem(req);
    endtask

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < DEPTH; i++) begin ram[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy at reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done at reset", int'(done), 0);
        chk(arr_we == 1'b0, "R1", "arr_we at reset", int'(arr_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset release", int'(busy), 0);

        run_cmd(16'hC005, 1, 1, 1, 0, "R2");        // top bits ignored
        run_cmd(16'h1040, 64, 1, 1, 0, "R4");       // full page
        run_cmd(16'h2FFC, 10, 1, 1, 0, "R3");       // in-page wrap
        run_cmd(16'h0803, 70, 1, 1, 0, "R3");       // wrap with overwrite
        run_cmd(16'hFFFF, 3, 1, 1, 0, "R2");        // last byte, top bits set
        run_cmd(16'h0500, 5, 0, 1, 0, "R5");        // misaligned rise
        run_cmd(16'h0600, 7, 1, 0, 0, "R7");        // no permission
        run_cmd(16'h0700, 0, 1, 1, 0, "R6");        // no bytes
        run_cmd(16'h0900, 12, 0, 1, 0, "R5");       // cancelled ...
        run_cmd(16'h0900, 2, 1, 1, 0, "R11");       // ... then short command, same page
        run_cmd(16'h0A10, 4, 1, 1, 1, "R10");       // foreign command while busy

        for (int r = 0; r < 30; r++) begin
            run_cmd(16'($urandom), int'($urandom % 70), ($urandom % 8) != 0,
                    ($urandom % 8) != 0, 0, "R4");
        end

        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule